// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the register face of one bus-master DMA channel for a disk-style controller. Software sees three registers: a command byte, a status byte, and a descriptor-table base address. The base address takes byte, halfword or word writes at any byte offset. The block turns changes of the command's start bit into one-cycle start and stop requests for the descriptor engine that sits behind it. When a transfer starts, it copies the base address into a working table pointer that the engine walks.

The block also watches the interrupt request coming from the drive side. It records each rising request in a sticky status flag and forwards the request level to the host interrupt line. Software clears the flag by writing a one to it.

All register state updates on the clock edge that samples a write. Read data is combinational from the current state, so a read returns the result of every earlier write.

Top module: `busmaster_regs`

## Requirements
- R1: A command write whose start bit (bit 0) equals the stored start bit raises neither `startReq` nor `stopReq` and leaves `workPtr` and the active flag unchanged.
- R2: A command write that changes the start bit from 0 to 1 loads `workPtr` from the base register and sets the active status flag. If the channel was not already active, `startReq` is high for exactly the one cycle after the write edge.
- R3: A command write that changes the start bit from 1 to 0 clears the active status flag, and `stopReq` is high for exactly the one cycle after the write edge.
- R4: The command register keeps only bit 0 (start) and bit 3 (direction, also driven on `dirOut`). It reads back with every other bit zero.
- R5: A base write (`regSel`=2) replaces only the byte lanes from `byteOff` up to `byteOff`+size-1 that fall inside the 32-bit word. `accSize` encodes the size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Write data is taken from the low end of `wrData`.
- R6: Bits 1:0 of the stored base address are always zero, whatever the width or offset of the write.
- R7: A base read returns the stored value shifted right by 8×`byteOff` and masked to the access size.
- R8: The status register (`regSel`=1) reads the active flag at bit 0 and the interrupt flag at bit 2, with all other bits zero. A status write cannot change the active flag.
- R9: A rising `driveIrq` sets the interrupt flag and drives `hostIrq` high one cycle later. A falling `driveIrq` lowers `hostIrq` one cycle later and leaves the flag set.
- R10: Writing status with bit 2 set clears the interrupt flag. A rising `driveIrq` in the same cycle wins, and the flag stays set.
- R11: Reset clears command, status, base, working pointer, request pulses and `hostIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 command, 1 status, 2 base address, 3 none |
| byteOff | input | 2 | Byte offset of the access within the register |
| accSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| wrData | input | 32 | Write data, low-aligned |
| rdData | output | 32 | Combinational read data of the selected register |
| driveIrq | input | 1 | Interrupt request from the drive side |
| hostIrq | output | 1 | Interrupt line toward the host |
| startReq | output | 1 | One-cycle request to begin descriptor walking |
| stopReq | output | 1 | One-cycle request to stop descriptor walking |
| dirOut | output | 1 | Stored direction bit |
| workPtr | output | 32 | Working descriptor-table pointer |

## Verification
Register contents and `workPtr` change on the write edge, so the bench reads them one time unit after that edge through the combinational `rdData`. `startReq` and `stopReq` are registered pulses that are valid only in the cycle right after the write edge. The bench samples them there, and on repeat writes it checks that they stay low in that same cycle. `hostIrq` and the interrupt flag lag `driveIrq` by one edge. The bench therefore changes `driveIrq` on a falling edge and checks both after the next rising edge.

// File: rtl/busmaster_pkg.sv
package busmaster_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;
  localparam int ST_ACT_BIT  = 0;
  localparam int ST_INT_BIT  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic cmdWr;   // store start/direction bits
    logic goRise;  // start bit 0 -> 1
    logic goFall;  // start bit 1 -> 0
    logic baseWr;  // base address lane write
    logic intClr;  // write-one-to-clear of interrupt flag
  } strobe_t;

endpackage

// File: rtl/busmaster_ctrl.sv
module busmaster_ctrl
  import busmaster_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              curGo,
  output strobe_t           strobes
);

  logic cmdHit;
  logic statHit;
  logic goNew;

  always_comb begin
    cmdHit  = wrEn && (regSel == SEL_CMD);
    statHit = wrEn && (regSel == SEL_STAT);
    goNew   = wrData[CMD_GO_BIT];

    strobes.cmdWr  = cmdHit;
    strobes.goRise = cmdHit && goNew && !curGo;
    strobes.goFall = cmdHit && !goNew && curGo;
    strobes.baseWr = wrEn && (regSel == SEL_BASE);
    strobes.intClr = statHit && wrData[ST_INT_BIT];
  end

  // R1: an unchanged start bit produces no edge strobe
  assert_no_edge_on_repeat_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && (goNew == curGo)) |-> !(strobes.goRise || strobes.goFall));

  assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.goRise && strobes.goFall));

endmodule

// File: rtl/busmaster_dp.sv
module busmaster_dp
  import busmaster_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [1:0]        regSel,
  input  logic [1:0]        byteOff,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              driveIrq,
  output logic [ADDR_W-1:0] rdData,
  output logic              curGo,
  output logic              hostIrq,
  output logic              startReq,
  output logic              stopReq,
  output logic              dirOut,
  output logic [ADDR_W-1:0] workPtr
);

  localparam int LANES = ADDR_W / 8;
  localparam int END_W = $clog2(LANES) + 3;

  logic              goBit;
  logic              dirBit;
  logic              active;
  logic              intFlag;
  logic              irqPrev;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] baseNext;
  logic [ADDR_W-1:0] shData;
  logic [ADDR_W-1:0] sizeMask;
  logic [END_W-1:0]  sizeBytes;
  logic [END_W-1:0]  endLane;
  logic              intRise;

  always_comb begin
    case (accSize)
      2'd0:    begin sizeBytes = END_W'(1);     sizeMask = ADDR_W'({8{1'b1}});  end
      2'd1:    begin sizeBytes = END_W'(2);     sizeMask = ADDR_W'({16{1'b1}}); end
      default: begin sizeBytes = END_W'(LANES); sizeMask = {ADDR_W{1'b1}};      end
    endcase
    endLane = END_W'(byteOff) + sizeBytes;
    shData  = wrData << {byteOff, 3'b000};
  end

  // Per-lane selection of the next base value
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic laneHit;
    assign laneHit = (END_W'(g) >= END_W'(byteOff)) && (END_W'(g) < endLane);
    assign baseNext[8*g +: 8] = laneHit ? shData[8*g +: 8] : base[8*g +: 8];
  end

  assign intRise = driveIrq && !irqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goBit    <= 1'b0;
      dirBit   <= 1'b0;
      active   <= 1'b0;
      intFlag  <= 1'b0;
      irqPrev  <= 1'b0;
      base     <= '0;
      workPtr  <= '0;
      startReq <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      startReq <= 1'b0;
      stopReq  <= 1'b0;
      irqPrev  <= driveIrq;
      if (strobes.cmdWr) begin
        goBit  <= wrData[CMD_GO_BIT];
        dirBit <= wrData[CMD_DIR_BIT];
      end
      if (strobes.goRise) begin
        workPtr <= base;
        if (!active) begin
          active   <= 1'b1;
          startReq <= 1'b1;
        end
      end
      if (strobes.goFall) begin
        active  <= 1'b0;
        stopReq <= 1'b1;
      end
      if (strobes.baseWr) begin
        base <= {baseNext[ADDR_W-1:2], 2'b00};
      end
      if (intRise) begin
        intFlag <= 1'b1;
      end else if (strobes.intClr) begin
        intFlag <= 1'b0;
      end
    end
  end

  assign curGo   = goBit;
  assign dirOut  = dirBit;
  assign hostIrq = irqPrev;

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_CMD: begin
        rdData[CMD_GO_BIT]  = goBit;
        rdData[CMD_DIR_BIT] = dirBit;
      end
      SEL_STAT: begin
        rdData[ST_ACT_BIT] = active;
        rdData[ST_INT_BIT] = intFlag;
      end
      SEL_BASE: rdData = (base >> {byteOff, 3'b000}) & sizeMask;
      default:  rdData = '0;
    endcase
  end

  assert_start_loads_ptr_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.goRise |=> (workPtr == $past(base)) && active);

  assert_stop_clears_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.goFall |=> !active && stopReq);

  assert_repeat_no_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmdWr && (wrData[CMD_GO_BIT] == goBit)) |=> !startReq && !stopReq);

  assert_base_low_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.baseWr |=> (base[1:0] == 2'b00));

  assert_byte_write_keeps_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.baseWr && accSize == 2'd0 && byteOff == 2'd1)
      |=> (base[ADDR_W-1:16] == $past(base[ADDR_W-1:16])));

  assert_irq_rise_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    intRise |=> intFlag && hostIrq);

  assert_irq_fall_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!driveIrq && irqPrev && intFlag && !strobes.intClr) |=> !hostIrq && intFlag);

  assert_status_keeps_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_STAT && !strobes.goRise && !strobes.goFall) |=> $stable(active));

endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import busmaster_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [1:0]        byteOff,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] rdData,
  input  logic              driveIrq,
  output logic              hostIrq,
  output logic              startReq,
  output logic              stopReq,
  output logic              dirOut,
  output logic [ADDR_W-1:0] workPtr
);

  strobe_t strobes;
  logic    curGo;

  busmaster_ctrl #(.DATA_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regSel  (regSel),
    .wrData  (wrData),
    .curGo   (curGo),
    .strobes (strobes)
  );

  busmaster_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regSel   (regSel),
    .byteOff  (byteOff),
    .accSize  (accSize),
    .wrData   (wrData),
    .driveIrq (driveIrq),
    .rdData   (rdData),
    .curGo    (curGo),
    .hostIrq  (hostIrq),
    .startReq (startReq),
    .stopReq  (stopReq),
    .dirOut   (dirOut),
    .workPtr  (workPtr)
  );

  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(startReq && stopReq));

endmodule

// File: tb/busmaster_regs_test.sv
`timescale 1ns/1ps
module busmaster_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [1:0]  byteOff = 2'd0;
  logic [1:0]  accSize = 2'd2;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        driveIrq = 1'b0;
  logic        hostIrq;
  logic        startReq;
  logic        stopReq;
  logic        dirOut;
  logic [31:0] workPtr;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  busmaster_regs uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .byteOff(byteOff),
    .accSize(accSize), .wrData(wrData), .rdData(rdData), .driveIrq(driveIrq),
    .hostIrq(hostIrq), .startReq(startReq), .stopReq(stopReq), .dirOut(dirOut),
    .workPtr(workPtr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Write on the next rising edge; returns 1 time unit after that edge
  task automatic writeReg(logic [1:0] sel, logic [1:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; byteOff = off; accSize = sz; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; regSel = 2'd3;
  endtask

  task automatic readReg(logic [1:0] sel, logic [1:0] off, logic [1:0] sz, output logic [31:0] d);
    regSel = sel; byteOff = off; accSize = sz;
    #0.5;
    d = rdData;
    regSel = 2'd3;
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(2'd0, 2'd0, 2'd0, v); check("R11 cmd after reset", v, 32'h0);
    readReg(2'd1, 2'd0, 2'd0, v); check("R11 status after reset", v, 32'h0);
    readReg(2'd2, 2'd0, 2'd2, v); check("R11 base after reset", v, 32'h0);
    check("R11 workPtr after reset", workPtr, 32'h0);
    check("R11 pulses/irq after reset", {29'b0, startReq, stopReq, hostIrq}, 32'h0);
  endtask

  task automatic testBase();
    logic [31:0] v;
    writeReg(2'd2, 2'd0, 2'd2, 32'h1234_5677);
    readReg(2'd2, 2'd0, 2'd2, v); check("R6 word write low bits", v, 32'h1234_5674);
    writeReg(2'd2, 2'd1, 2'd0, 32'hFFFF_FFAB);
    readReg(2'd2, 2'd0, 2'd2, v); check("R5 byte write at offset 1", v, 32'h1234_AB74);
    readReg(2'd2, 2'd1, 2'd0, v); check("R7 byte read offset 1", v, 32'h0000_00AB);
    readReg(2'd2, 2'd2, 2'd1, v); check("R7 half read offset 2", v, 32'h0000_1234);
    writeReg(2'd2, 2'd0, 2'd1, 32'h0000_FFFF);
    readReg(2'd2, 2'd0, 2'd2, v); check("R6 half write low bits", v, 32'h1234_FFFC);
    writeReg(2'd2, 2'd3, 2'd2, 32'h0000_00CD);
    readReg(2'd2, 2'd0, 2'd2, v); check("R5 word write at offset 3", v, 32'hCD34_FFFC);
  endtask

  task automatic testStart();
    logic [31:0] v;
    writeReg(2'd0, 2'd0, 2'd0, 32'h0000_00FF);
    check("R2 startReq pulse", {31'b0, startReq}, 32'h1);
    check("R2 workPtr loaded", workPtr, 32'hCD34_FFFC);
    readReg(2'd0, 2'd0, 2'd0, v); check("R4 cmd keeps bits 0 and 3", v, 32'h0000_0009);
    check("R4 dirOut", {31'b0, dirOut}, 32'h1);
    readReg(2'd1, 2'd0, 2'd0, v); check("R2 active set", v, 32'h0000_0001);
    @(posedge clk); #1;
    check("R2 startReq one cycle", {31'b0, startReq}, 32'h0);
  endtask

  task automatic testRepeat();
    logic [31:0] v;
    writeReg(2'd2, 2'd0, 2'd2, 32'h0000_0100);
    writeReg(2'd0, 2'd0, 2'd0, 32'h0000_0001);
    check("R1 no pulse on repeat start", {30'b0, startReq, stopReq}, 32'h0);
    check("R1 workPtr unchanged", workPtr, 32'hCD34_FFFC);
    readReg(2'd0, 2'd0, 2'd0, v); check("R4 direction rewritten", v, 32'h0000_0001);
    writeReg(2'd1, 2'd0, 2'd0, 32'h0000_00FB);
    readReg(2'd1, 2'd0, 2'd0, v); check("R8 status write keeps active", v, 32'h0000_0001);
  endtask

  task automatic testStop();
    logic [31:0] v;
    writeReg(2'd0, 2'd0, 2'd0, 32'h0000_0000);
    check("R3 stopReq pulse", {31'b0, stopReq}, 32'h1);
    readReg(2'd1, 2'd0, 2'd0, v); check("R3 active cleared", v, 32'h0);
    writeReg(2'd0, 2'd0, 2'd0, 32'h0000_0000);
    check("R1 no pulse on repeat stop", {30'b0, startReq, stopReq}, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    @(negedge clk); driveIrq = 1'b1;
    @(posedge clk); #1;
    check("R9 hostIrq follows rise", {31'b0, hostIrq}, 32'h1);
    readReg(2'd1, 2'd0, 2'd0, v); check("R9 int flag set", v, 32'h0000_0004);
    @(negedge clk); driveIrq = 1'b0;
    @(posedge clk); #1;
    check("R9 hostIrq follows fall", {31'b0, hostIrq}, 32'h0);
    readReg(2'd1, 2'd0, 2'd0, v); check("R9 flag kept on fall", v, 32'h0000_0004);
    writeReg(2'd1, 2'd0, 2'd0, 32'h0000_0004);
    readReg(2'd1, 2'd0, 2'd0, v); check("R10 write-one clears", v, 32'h0);
    @(negedge clk);
    driveIrq = 1'b1; wrEn = 1'b1; regSel = 2'd1; wrData = 32'h4;
    @(posedge clk); #1;
    wrEn = 1'b0;
    readReg(2'd1, 2'd0, 2'd0, v); check("R10 rise wins over clear", v, 32'h0000_0004);
  endtask

  task automatic testResetMid();
    logic [31:0] v;
    writeReg(2'd0, 2'd0, 2'd0, 32'h0000_0009);
    @(negedge clk); rstN = 1'b0;
    #7; rstN = 1'b1; driveIrq = 1'b0;
    @(posedge clk); #1;
    readReg(2'd0, 2'd0, 2'd0, v); check("R11 cmd cleared", v, 32'h0);
    readReg(2'd1, 2'd0, 2'd0, v); check("R11 status cleared", v, 32'h0);
    readReg(2'd2, 2'd0, 2'd2, v); check("R11 base cleared", v, 32'h0);
    check("R11 workPtr cleared", workPtr, 32'h0);
  endtask

  initial begin
    #20 rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBase();
    testStart();
    testRepeat();
    testStop();
    testIrq();
    testResetMid();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #200000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule